// File: doc/BRIEF.md
# ADC Output Overload Flag and Startup Mute

This block sits between a stereo decimation path and the serial output of an audio converter. Each time the sample strobe fires, at the sample rate fs, it looks at the signed left and right samples. If either one comes close to digital full scale, it raises an overload flag. The flag then stays high for a fixed number of sample periods, and every further overload sample restarts that hold time.

The same block forces the outgoing sample pair to zero after reset or after a restart pulse, so the serial output reads LOW until the upstream filters have settled. How long that wait lasts depends on whether the DC-removal high-pass filter is enabled. The filters themselves live elsewhere.

Top module: `adc_out_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `overFlag` is 0 and `leftOut` and `rightOut` are 0.
- R2: A strobed sample pair counts as an overload when the magnitude of either channel exceeds 458752 (0x70000, about -1.16 dB of 20-bit full scale). A magnitude exactly equal to 458752 is not an overload. In that case `overFlag` reads 1 on the cycle after the strobe edge.
- R3: The negative full-scale code 0x80000 on either channel counts as an overload.
- R4: After an overload sample, `overFlag` stays 1 through the next 511 non-overload strobes. It falls on the 512th non-overload strobe.
- R5: An overload sample that arrives while the flag is high restarts the 512-strobe hold count.
- R6: With `dcFiltEn` = 0, the first 1024 strobes after reset or restart produce `leftOut` = `rightOut` = 0. The 1025th strobed pair passes through unchanged.
- R7: With `dcFiltEn` = 1, the mute lasts 12288 strobes. The 12289th strobed pair passes through.
- R8: Changing `dcFiltEn` during the mute applies the new length to the strobes already counted. For example, clearing it after 2000 strobes lets the next strobe pass.
- R9: A `restart` pulse clears the flag and the outputs on the next cycle and starts a new mute.
- R10: Without a strobe, the outputs hold their value and the input samples have no effect on them or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One-cycle strobe, once per sample period |
| restart | input | 1 | Synchronous restart pulse (power-up or clock start) |
| dcFiltEn | input | 1 | DC-removal filter enabled; selects the long mute |
| leftIn | input | 20 | Left sample, signed two's complement |
| rightIn | input | 20 | Right sample, signed two's complement |
| overFlag | output | 1 | Overload flag |
| leftOut | output | 20 | Left sample after muting |
| rightOut | output | 20 | Right sample after muting |

## Verification
A wrong hold count shows up as `overFlag` falling one or more strobes too early or too late. The bench probes the strobes at both ends of the 512-strobe window, directly after a single overload and after a retrigger. A mute counter that is off by one, or tied to the wrong length, passes a sample one strobe early or keeps the output at zero one strobe too long. Both errors are seen on the strobe right at each mute boundary and also when the enable is switched mid-mute. A threshold error near ±0x70000 or at 0x80000 flips the flag on the very next cycle.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearOut;   // force outputs to zero now
    logic loadOut;    // capture a new output pair
    logic passSample; // captured pair carries data, not zero
  } guard_strobes_t;
endpackage

// File: rtl/adc_guard_datapath.sv
module adc_guard_datapath
  import adc_guard_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int THRESH   = 458752
) (
  input  logic                clk,
  input  logic                rst_n,
  input  guard_strobes_t      strb,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                overHit,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut
);
  localparam int CHANS = 2;
  localparam logic [SAMPLE_W-1:0] THRESH_V = SAMPLE_W'(THRESH);

  logic [CHANS-1:0][SAMPLE_W-1:0] sampIn;
  logic [CHANS-1:0][SAMPLE_W-1:0] sampOut;
  logic [CHANS-1:0]               chanHit;

  assign sampIn[0] = leftIn;
  assign sampIn[1] = rightIn;

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    logic [SAMPLE_W-1:0] mag;
    // unsigned magnitude; most negative code maps to 2^(W-1)
    assign mag = sampIn[c][SAMPLE_W-1] ? (~sampIn[c] + 1'b1) : sampIn[c];
    assign chanHit[c] = mag > THRESH_V;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             sampOut[c] <= '0;
      else if (strb.clearOut) sampOut[c] <= '0;
      else if (strb.loadOut)  sampOut[c] <= strb.passSample ? sampIn[c] : '0;
    end
  end

  assign overHit  = |chanHit;
  assign leftOut  = sampOut[0];
  assign rightOut = sampOut[1];
endmodule

// File: rtl/adc_guard_control.sv
module adc_guard_control
  import adc_guard_pkg::*;
#(
  parameter int HOLD_LEN   = 512,
  parameter int MUTE_SHORT = 1024,
  parameter int MUTE_LONG  = 12288
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sampleStb,
  input  logic           restart,
  input  logic           dcFiltEn,
  input  logic           overHit,
  output guard_strobes_t strb,
  output logic           overFlag
);
  localparam int HOLD_W = $clog2(HOLD_LEN + 1);
  localparam int MUTE_MAX = (MUTE_LONG > MUTE_SHORT) ? MUTE_LONG : MUTE_SHORT;
  localparam int MUTE_W = $clog2(MUTE_MAX + 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [MUTE_W-1:0] muteCnt;
  logic [MUTE_W-1:0] muteLimit;
  logic              muted;

  assign muteLimit = dcFiltEn ? MUTE_W'(MUTE_LONG) : MUTE_W'(MUTE_SHORT);
  assign muted     = muteCnt < muteLimit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
      muteCnt <= '0;
    end else if (restart) begin
      holdCnt <= '0;
      muteCnt <= '0;
    end else if (sampleStb) begin
      if (overHit)             holdCnt <= HOLD_W'(HOLD_LEN);
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
      if (muted)               muteCnt <= muteCnt + 1'b1;
    end
  end

  assign overFlag        = holdCnt != '0;
  assign strb.clearOut   = restart;
  assign strb.loadOut    = sampleStb;
  assign strb.passSample = !muted;
endmodule

// File: rtl/adc_out_guard.sv
module adc_out_guard
  import adc_guard_pkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int HOLD_LEN   = 512,
  parameter int MUTE_SHORT = 1024,
  parameter int MUTE_LONG  = 12288
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleStb,
  input  logic                restart,
  input  logic                dcFiltEn,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                overFlag,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut
);
  // 0.875 of positive full scale, about -1.16 dB
  localparam int THRESH = (7 * (1 << (SAMPLE_W - 1))) / 8;

  guard_strobes_t strb;
  logic           overHit;

  adc_guard_control #(
    .HOLD_LEN(HOLD_LEN), .MUTE_SHORT(MUTE_SHORT), .MUTE_LONG(MUTE_LONG)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .restart(restart),
    .dcFiltEn(dcFiltEn), .overHit(overHit), .strb(strb), .overFlag(overFlag)
  );

  adc_guard_datapath #(
    .SAMPLE_W(SAMPLE_W), .THRESH(THRESH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .leftIn(leftIn), .rightIn(rightIn),
    .overHit(overHit), .leftOut(leftOut), .rightOut(rightOut)
  );
endmodule

// File: rtl/adc_guard_checker.sv
module adc_guard_checker #(
  parameter int SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sampleStb,
  input logic                restart,
  input logic                overHit,
  input logic                overFlag,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!overFlag && leftOut == '0 && rightOut == '0));

  // R2
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && overHit && !restart) |=> overFlag);

  // R4
  flag_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overFlag) |-> $past(sampleStb));

  // R4
  flag_fall_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overFlag) |-> ($past(sampleStb) || $past(restart)));

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!overFlag && leftOut == '0 && rightOut == '0));

  // R10
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleStb && !restart) |=> ($stable(leftOut) && $stable(rightOut) && $stable(overFlag)));
endmodule

bind adc_out_guard adc_guard_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .restart(restart),
  .overHit(overHit), .overFlag(overFlag), .leftOut(leftOut), .rightOut(rightOut)
);

// File: tb/adc_out_guard_bench.sv
module adc_out_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleStb = 1'b0;
  logic        restart = 1'b0;
  logic        dcFiltEn = 1'b0;
  logic [19:0] leftIn = '0;
  logic [19:0] rightIn = '0;
  logic        overFlag;
  logic [19:0] leftOut, rightOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_out_guard u_adc_out_guard (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .restart(restart),
    .dcFiltEn(dcFiltEn), .leftIn(leftIn), .rightIn(rightIn),
    .overFlag(overFlag), .leftOut(leftOut), .rightOut(rightOut)
  );

  // {left, right, expected flag}
  localparam logic [40:0] VEC [8] = '{
    {20'h70000, 20'h00000, 1'b0},  // R2 equal to threshold
    {20'h00000, 20'h90000, 1'b0},  // R2 negative equal
    {20'h70001, 20'h00000, 1'b1},  // R2 just above
    {20'h00000, 20'h8FFFF, 1'b1},  // R2 just below negative
    {20'h80000, 20'h00000, 1'b1},  // R3 negative full scale
    {20'h00000, 20'h7FFFF, 1'b1},  // R2 positive full scale
    {20'h12345, 20'hEDCBA, 1'b0},  // R2 small values
    {20'h90000, 20'h90000, 1'b0}   // R2 both at threshold
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doStb(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk);
    leftIn = l; rightIn = r; sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic pulseRestart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic runStb(input int n, input logic [19:0] l, input logic [19:0] r);
    for (int i = 0; i < n; i++) doStb(l, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag in reset", overFlag, 0);
    check("R1 left in reset", leftOut, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", overFlag, 0);
    check("R1 right after reset", rightOut, 0);

    // threshold table, each row starts from a cleared flag
    for (int v = 0; v < 8; v++) begin
      pulseRestart();
      doStb(VEC[v][40:21], VEC[v][20:1]);
      check($sformatf("R2/R3 vector %0d flag", v), overFlag, VEC[v][0]);
    end

    // R6 short mute
    pulseRestart();
    runStb(1024, 20'h00005, 20'h00006);
    check("R6 last muted strobe left", leftOut, 0);
    check("R6 last muted strobe right", rightOut, 0);
    doStb(20'h00007, 20'hFFFF9);
    check("R6 first passed left", leftOut, 20'h00007);
    check("R6 first passed right", rightOut, 20'hFFFF9);

    // R10 no strobe, overload-sized input
    @(negedge clk);
    leftIn = 20'h80000; rightIn = 20'h80000;
    repeat (3) @(negedge clk);
    check("R10 left held", leftOut, 20'h00007);
    check("R10 flag untouched", overFlag, 0);

    // R4 hold length
    doStb(20'h7FFFF, 20'h00001);
    check("R4 flag set", overFlag, 1);
    check("R4 sample passed", leftOut, 20'h7FFFF);
    runStb(511, 20'h00010, 20'h00010);
    check("R4 flag after 511", overFlag, 1);
    doStb(20'h00010, 20'h00010);
    check("R4 flag after 512", overFlag, 0);

    // R5 retrigger
    doStb(20'h00000, 20'h80000);
    runStb(300, 20'h00001, 20'h00001);
    doStb(20'h70001, 20'h00000);
    runStb(511, 20'h00001, 20'h00001);
    check("R5 flag held by retrigger", overFlag, 1);
    doStb(20'h00001, 20'h00001);
    check("R5 flag drops after retrigger hold", overFlag, 0);

    // R9 restart clears
    doStb(20'h7FFFF, 20'h7FFFF);
    check("R9 flag before restart", overFlag, 1);
    pulseRestart();
    check("R9 flag cleared", overFlag, 0);
    check("R9 output cleared", leftOut, 0);

    // R7 long mute
    dcFiltEn = 1'b1;
    pulseRestart();
    runStb(1025, 20'h00003, 20'h00003);
    check("R7 still muted past short length", leftOut, 0);
    runStb(12288 - 1025, 20'h00003, 20'h00003);
    check("R7 last muted strobe", rightOut, 0);
    doStb(20'h00123, 20'h00456);
    check("R7 first passed left", leftOut, 20'h00123);
    check("R7 first passed right", rightOut, 20'h00456);

    // R8 enable change mid-mute
    pulseRestart();
    runStb(2000, 20'h00009, 20'h00009);
    check("R8 muted at 2000 in long mode", leftOut, 0);
    dcFiltEn = 1'b0;
    doStb(20'h00abc, 20'h00def);
    check("R8 passes after switch to short", leftOut, 20'h00abc);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule